// File: doc/BRIEF.md
# Loadable Up/Down Counter with Terminal-Count Pulse

The block is a small counter register that can step up or down by one, take a parallel value, or be cleared to zero, all on the rising clock edge. Its terminal-count flag marks the last value before a wrap in the selected direction. In up mode that value is all ones. In down mode it is all zeros.

The usual use is as a programmable pulse divider. Set the direction to down, drive the load value with N-1 and feed the terminal-count output back into the load input. The counter then runs N-1, N-2, ..., 0 and reloads, so the flag is high for one cycle in every N. That flag is an enable pulse for other logic, not a derived clock. With the direction set to up and no feedback, the counter wraps naturally every 2^W cycles.

Top module: `ctr_divider`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `count` becomes 0 after that edge.
- R2: With `clear`=0, `load`=0, `step_en`=1 and `down`=0, `count` becomes `count`+1 modulo 2^W after the edge.
- R3: With `clear`=0, `load`=0, `step_en`=1 and `down`=1, `count` becomes `count`-1 modulo 2^W after the edge.
- R4: Stepping up from all ones gives 0. Stepping down from 0 gives all ones.
- R5: `term` is combinational and does not depend on `step_en`. With `down`=0 it is 1 exactly when `count` is all ones. With `down`=1 it is 1 exactly when `count` is 0.
- R6: With `clear`=0 and `load`=1, `count` takes `load_val` after the edge, whatever `step_en` and `down` are.
- R7: With `clear`=1, `count` becomes 0 after the edge, even when `load` or `step_en` is also 1.
- R8: With `clear`, `load` and `step_en` all 0, `count` keeps its value.
- R9: In divider use (`down`=1, `load` driven by `term`, `load_val`=N-1), `term` is high in exactly one cycle out of every N, starting from the cycle after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step the count by one in the selected direction |
| down | input | 1 | Direction: 0 steps up, 1 steps down |
| clear | input | 1 | Synchronous clear to zero; has the highest priority |
| load | input | 1 | Parallel load of `load_val`; ranks above stepping |
| load_val | input | W | Value taken on a load |
| count | output | W | Current count |
| term | output | 1 | Terminal count for the selected direction |

## Verification
The bench starts from every count value and applies every combination of clear, load, step and direction. This exposes a design that ranks load above clear, or steps while loading. It also catches a design whose wrap at all ones or at zero goes to the wrong value, for example one that saturates instead of wrapping. On every vector the bench checks `term` against the direction. A flag that ignores `down`, or that is masked by `step_en`, would then miss its cycle. Finally, a divider closed through `term` is run for every N from 2 to 16. An off-by-one in the reload, such as loading N instead of N-1, shows up as a pulse spacing of N+1.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic step;
    } ctl_t;

    // Fixed ranking: clear, then load, then step.
    function automatic op_e pick_op(ctl_t c);
        if (c.clear)
            return OP_CLEAR;
        else if (c.load)
            return OP_LOAD;
        else if (c.step)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ctr_ctl.sv
module ctr_ctl
    import ctr_pkg::*;
(
    input  ctl_t ctl,
    output op_e  op
);
    always_comb op = pick_op(ctl);
endmodule

// File: rtl/ctr_stepper.sv
module ctr_stepper
    import ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    output logic [W-1:0] nxt
);
    localparam int CW = W + 1;

    logic [CW-1:0] carry;
    logic [CW-1:0] borrow;
    logic [W-1:0]  inc_v;
    logic [W-1:0]  dec_v;

    assign carry[0]  = 1'b1;
    assign borrow[0] = 1'b1;

    // Half-adder chain for +1 and half-subtractor chain for -1.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign inc_v[i]      = cur[i] ^ carry[i];
        assign carry[i+1]    = cur[i] & carry[i];
        assign dec_v[i]      = cur[i] ^ borrow[i];
        assign borrow[i+1]   = ~cur[i] & borrow[i];
    end

    always_comb nxt = (dir == DIR_DOWN) ? dec_v : inc_v;

    // The carry and borrow out of the top bit go unused: the count wraps.
    logic unused_ok;
    assign unused_ok = carry[W] ^ borrow[W];
endmodule

// File: rtl/ctr_term.sv
module ctr_term
    import ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    output logic         term
);
    logic all_ones;
    logic all_zero;

    assign all_ones = &cur;
    assign all_zero = ~|cur;

    always_comb term = (dir == DIR_DOWN) ? all_zero : all_ones;
endmodule

// File: rtl/ctr_divider.sv
module ctr_divider
    import ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         down,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         term
);
    localparam logic [W-1:0] ZERO = '0;

    dir_e          dsel;
    ctl_t          ctl;
    op_e           op;
    logic [W-1:0]  stepped;
    logic [W-1:0]  cnt_q;

    assign dsel      = dir_e'(down);
    assign ctl.clear = clear;
    assign ctl.load  = load;
    assign ctl.step  = step_en;

    ctr_ctl u_ctl (
        .ctl (ctl),
        .op  (op)
    );

    ctr_stepper #(.W(W)) u_step (
        .cur (cnt_q),
        .dir (dsel),
        .nxt (stepped)
    );

    ctr_term #(.W(W)) u_term (
        .cur  (cnt_q),
        .dir  (dsel),
        .term (term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
        end else begin
            unique case (op)
                OP_CLEAR: cnt_q <= ZERO;
                OP_LOAD:  cnt_q <= load_val;
                OP_STEP:  cnt_q <= stepped;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

    // R1: reset gives zero
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> count == ZERO);

    // R2: step up adds one
    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load && step_en && !down) |=> count == W'($past(count) + 1'b1));

    // R3: step down subtracts one
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load && step_en && down) |=> count == W'($past(count) - 1'b1));

    // R6: load takes the external value
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (!clear && load) |=> count == $past(load_val));

    // R7: clear wins over everything else
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == ZERO);

    // R8: idle holds the count
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load && !step_en) |=> $stable(count));
endmodule

// File: tb/tb_ctr_divider.sv
module tb_ctr_divider;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic         step_en;
    logic         down;
    logic         clear;
    logic         load_drv;
    logic         fb_on;
    logic [W-1:0] load_val;
    logic [W-1:0] count;
    logic         term;
    logic         load_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    assign load_in = fb_on ? term : load_drv;

    ctr_divider #(.W(W)) dut (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .down     (down),
        .clear    (clear),
        .load     (load_in),
        .load_val (load_val),
        .count    (count),
        .term     (term)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_term(input int c, input bit dn);
        return dn ? int'(c == 0) : int'(c == M - 1);
    endfunction

    // Inputs change 1 ns after a rising edge; results are sampled 1 ns after the next.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; step_en = 1'b0; down = 1'b0; clear = 1'b0;
        load_drv = 1'b0; fb_on = 1'b0; load_val = '0;
        tick();
        tick();
        check("R1 reset", int'(count), 0);
        rst = 1'b0;

        // Sweep: every start value times every control combination.
        for (int v = 0; v < M; v++) begin
            for (int k = 0; k < 16; k++) begin
                int    lv;
                int    ex;
                string tag;
                bit    c, l, s, d;
                c = k[3]; l = k[2]; s = k[1]; d = k[0];
                lv = (v * 7 + k + 3) % M;
                // Preload the start value (R6).
                clear = 1'b0; load_drv = 1'b1; step_en = 1'b0; down = 1'b0;
                load_val = W'(v);
                tick();
                check("R6 preload", int'(count), v);
                // Apply the combination.
                clear = c; load_drv = l; step_en = s; down = d; load_val = W'(lv);
                #1;
                check("R5 term", int'(term), exp_term(v, d));
                if (c) begin
                    ex = 0; tag = "R7 clear";
                end else if (l) begin
                    ex = lv; tag = "R6 load";
                end else if (s && !d) begin
                    ex = (v + 1) % M;
                    tag = (v == M - 1) ? "R4 wrap up" : "R2 up";
                end else if (s && d) begin
                    ex = (v + M - 1) % M;
                    tag = (v == 0) ? "R4 wrap down" : "R3 down";
                end else begin
                    ex = v; tag = "R8 hold";
                end
                tick();
                check(tag, int'(count), ex);
                #1;
                check("R5 term after", int'(term), exp_term(ex, d));
            end
        end

        // Divider: term fed back into load, load value N-1, down mode.
        for (int n = 2; n <= M; n++) begin
            fb_on = 1'b0; load_drv = 1'b0; step_en = 1'b1; down = 1'b1;
            load_val = W'(n - 1);
            clear = 1'b1;
            tick();
            clear = 1'b0;
            fb_on = 1'b1;
            for (int t = 0; t < 3 * n; t++) begin
                #1;
                check("R9 divider", int'(term), int'((t % n) == 0));
                tick();
            end
            fb_on = 1'b0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule